// File: doc/BRIEF.md
# Sequential Integer Divide Unit

This unit performs the unsigned and signed register-divide operations of a 64-bit load/store processor. A request presents a 32-bit instruction word and two 64-bit source values together with `start`. The unit decodes the two-source data-processing fields, sorts out encodings that it cannot execute, extends the operands for 32-bit mode and produces the quotient. It uses a radix-2 restoring loop that retires one quotient bit per clock. Quotients whose value is known at once (zero divisor, the one signed overflow case, rejected encodings) skip the loop. In every case the answer is returned with a one-cycle `done` pulse that also carries the destination register index.

Signed division works on operand magnitudes. The quotient is negated when the operand signs differ, so the result truncates toward zero. The control path is a four-state machine:
- `ST_IDLE` waits for `start`.
- `ST_CALC` runs the 64 shift-subtract iterations.
- `ST_FINAL` applies the sign and the 32-bit zero extension.
- `ST_RESP` drives the `done` pulse.

The transitions are:
- IDLE→RESP on an immediate-result request.
- IDLE→CALC on any other accepted request.
- CALC→FINAL after the last iteration.
- FINAL→RESP.
- RESP→IDLE.
- Reset forces IDLE from any state.

Top module: `intdiv_unit`

## Requirements
- R1: The instruction fields are read at fixed positions: bit 31 selects 64-bit width when 1, bit 29 is the flag-setting bit, bits 15:10 are the 6-bit opcode and bits 4:0 are the destination index. `done_rd` returns bits 4:0 of the accepted instruction.
- R2: If bit 29 is 1, the response has `done_unalloc`=1, `done_unhandled`=0 and result 0, and no division is performed. `done` follows in the cycle after acceptance.
- R3: Opcode 2 is an unsigned divide and opcode 3 is a signed divide. When bit 29 is 0, any other opcode gives `done_unhandled`=1, `done_unalloc`=0 and result 0, with `done` in the cycle after acceptance.
- R4: A 64-bit unsigned divide with a nonzero divisor returns the unsigned quotient. `done` rises 65 cycles after the acceptance edge.
- R5: A 64-bit signed divide returns the quotient truncated toward zero, with the same 65-cycle latency.
- R6: A zero divisor gives a result of 0 for both signednesses, with `done` in the cycle after acceptance.
- R7: A signed 64-bit divide of 0x8000_0000_0000_0000 by all-ones returns 0x8000_0000_0000_0000, with `done` in the cycle after acceptance.
- R8: In 32-bit mode a signed divide sign-extends the low 32 bits of both sources and ignores their upper halves.
- R9: In 32-bit mode an unsigned divide zero-extends the low 32 bits of both sources and ignores their upper halves.
- R10: In 32-bit mode bits 63:32 of the result are 0.
- R11: `busy` is high from the edge that accepts a request until the end of the `done` cycle. A `start` seen while `busy` is high is ignored.
- R12: `done` is a single-cycle pulse. `done_rd`, `done_result`, `done_unalloc` and `done_unhandled` are valid while it is high.
- R13: A synchronous active-high `rst` clears `busy` and `done` and abandons any divide in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, sampled when not busy |
| insn | input | 32 | Instruction word |
| src_n | input | 64 | Dividend source value |
| src_m | input | 64 | Divisor source value |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle response strobe |
| done_rd | output | 5 | Destination register index |
| done_result | output | 64 | Quotient or special result |
| done_unalloc | output | 1 | Encoding was unallocated |
| done_unhandled | output | 1 | Opcode is not a divide |

## Verification
The delivery of a response and the arrival of a new request can fall in the same cycle. This happens when `start` is high during the `done` cycle. The bench provokes it by holding `start` high without a break across several responses, first for immediate-result requests and then for looped ones. It also raises `start` with a different instruction in the middle of a running divide. The behavioural model accepts a request only when its own busy state is clear. On every clock it checks that a request overlapping a response is not taken until the cycle after `done`, and that the result and destination index still belong to the earlier request.

// File: rtl/intdiv_pkg.sv
package intdiv_pkg;

    // instruction field layout (decoded by the register-divide path)
    localparam int INSN_W    = 32;
    localparam int SF_BIT    = 31;
    localparam int S_BIT     = 29;
    localparam int OP_LSB    = 10;
    localparam int OP_W      = 6;
    localparam int RD_LSB    = 0;
    localparam int REG_IDX_W = 5;

    localparam logic [OP_W-1:0] OP_UDIV = 6'd2;
    localparam logic [OP_W-1:0] OP_SDIV = 6'd3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CALC  = 2'd1,
        ST_FINAL = 2'd2,
        ST_RESP  = 2'd3
    } div_state_e;

    typedef struct packed {
        logic                 sf;
        logic                 unalloc;
        logic                 unhandled;
        logic                 div_zero;
        logic                 ovf;
        logic                 neg_q;
        logic [REG_IDX_W-1:0] rd;
    } div_ctl_t;

endpackage

// File: rtl/intdiv_decode.sv
module intdiv_decode
    import intdiv_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [INSN_W-1:0] insn,
    input  logic [XLEN-1:0]   opa,
    input  logic [XLEN-1:0]   opb,
    output div_ctl_t          ctl,
    output logic [XLEN-1:0]   mag_a,
    output logic [XLEN-1:0]   mag_b
);

    localparam int HALF = XLEN / 2;
    localparam logic [XLEN-1:0] MIN_VAL = {1'b1, {(XLEN-1){1'b0}}};

    logic [OP_W-1:0] opcode;
    logic            wide;
    logic            s_bit;
    logic            is_div;
    logic            is_sgn;
    logic [XLEN-1:0] ext_a;
    logic [XLEN-1:0] ext_b;
    logic            neg_a;
    logic            neg_b;

    // register index fields of the sources and fixed group bits are not used here
    logic unused_fields;
    assign unused_fields = ^{insn[30], insn[28:OP_LSB+OP_W], insn[OP_LSB-1:RD_LSB+REG_IDX_W]};

    function automatic logic [XLEN-1:0] narrow_ext(input logic [XLEN-1:0] v, input logic sgn);
        return {{HALF{sgn & v[HALF-1]}}, v[HALF-1:0]};
    endfunction

    always_comb begin
        opcode = insn[OP_LSB +: OP_W];
        wide   = insn[SF_BIT];
        s_bit  = insn[S_BIT];
        is_div = (opcode == OP_UDIV) || (opcode == OP_SDIV);
        is_sgn = (opcode == OP_SDIV);

        ext_a  = wide ? opa : narrow_ext(opa, is_sgn);
        ext_b  = wide ? opb : narrow_ext(opb, is_sgn);

        neg_a  = is_sgn & ext_a[XLEN-1];
        neg_b  = is_sgn & ext_b[XLEN-1];
        mag_a  = neg_a ? (~ext_a + 1'b1) : ext_a;
        mag_b  = neg_b ? (~ext_b + 1'b1) : ext_b;

        ctl.sf        = wide;
        ctl.unalloc   = s_bit;
        ctl.unhandled = !s_bit && !is_div;
        ctl.div_zero  = (ext_b == '0);
        ctl.ovf       = is_sgn && (ext_a == MIN_VAL) && (ext_b == '1);
        ctl.neg_q     = neg_a ^ neg_b;
        ctl.rd        = insn[RD_LSB +: REG_IDX_W];
    end

endmodule

// File: rtl/intdiv_core.sv
module intdiv_core #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            step,
    input  logic [XLEN-1:0] dividend,
    input  logic [XLEN-1:0] divisor,
    output logic [XLEN-1:0] quotient,
    output logic            last
);

    localparam int CNT_W = $clog2(XLEN);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(XLEN - 1);

    logic [XLEN:0]    rem_q;
    logic [XLEN-1:0]  quo_q;
    logic [XLEN-1:0]  dsr_q;
    logic [CNT_W-1:0] cnt_q;

    logic [XLEN:0]    shifted;
    logic [XLEN:0]    diff;
    logic             fits;

    always_comb begin
        shifted = {rem_q[XLEN-1:0], quo_q[XLEN-1]};
        diff    = shifted - {1'b0, dsr_q};
        fits    = !diff[XLEN];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
            dsr_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            rem_q <= '0;
            quo_q <= dividend;
            dsr_q <= divisor;
            cnt_q <= '0;
        end else if (step) begin
            rem_q <= fits ? diff : shifted;
            quo_q <= {quo_q[XLEN-2:0], fits};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign quotient = quo_q;
    assign last     = (cnt_q == LAST_CNT);

endmodule

// File: rtl/intdiv_fixup.sv
module intdiv_fixup #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] quo,
    input  logic            neg_l,
    input  logic            sf_l,
    input  logic            void_op,
    input  logic            ovf,
    input  logic            sf_now,
    output logic [XLEN-1:0] res_calc,
    output logic [XLEN-1:0] res_fast
);

    localparam int HALF = XLEN / 2;
    localparam logic [XLEN-1:0] MIN_VAL = {1'b1, {(XLEN-1){1'b0}}};

    function automatic logic [XLEN-1:0] narrow(input logic [XLEN-1:0] v, input logic wide);
        return wide ? v : {{HALF{1'b0}}, v[HALF-1:0]};
    endfunction

    logic [XLEN-1:0] signed_q;

    always_comb begin
        signed_q = neg_l ? (~quo + 1'b1) : quo;
        res_calc = narrow(signed_q, sf_l);
        res_fast = narrow((!void_op && ovf) ? MIN_VAL : '0, sf_now);
    end

endmodule

// File: rtl/intdiv_unit.sv
module intdiv_unit
    import intdiv_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [INSN_W-1:0]    insn,
    input  logic [XLEN-1:0]      src_n,
    input  logic [XLEN-1:0]      src_m,
    output logic                 busy,
    output logic                 done,
    output logic [REG_IDX_W-1:0] done_rd,
    output logic [XLEN-1:0]      done_result,
    output logic                 done_unalloc,
    output logic                 done_unhandled
);

    div_state_e state_q;
    div_state_e state_d;

    div_ctl_t        ctl;
    logic [XLEN-1:0] mag_n;
    logic [XLEN-1:0] mag_m;
    logic [XLEN-1:0] core_q;
    logic [XLEN-1:0] res_calc;
    logic [XLEN-1:0] res_fast;
    logic            core_last;
    logic            void_op;
    logic            fast;
    logic            accept;
    logic            core_load;
    logic            core_step;

    logic [REG_IDX_W-1:0] rd_q;
    logic [XLEN-1:0]      res_q;
    logic                 ua_q;
    logic                 uh_q;
    logic                 neg_l;
    logic                 sf_l;

    intdiv_decode #(.XLEN(XLEN)) u_decode (
        .insn  (insn),
        .opa   (src_n),
        .opb   (src_m),
        .ctl   (ctl),
        .mag_a (mag_n),
        .mag_b (mag_m)
    );

    intdiv_core #(.XLEN(XLEN)) u_core (
        .clk      (clk),
        .rst      (rst),
        .load     (core_load),
        .step     (core_step),
        .dividend (mag_n),
        .divisor  (mag_m),
        .quotient (core_q),
        .last     (core_last)
    );

    intdiv_fixup #(.XLEN(XLEN)) u_fixup (
        .quo      (core_q),
        .neg_l    (neg_l),
        .sf_l     (sf_l),
        .void_op  (void_op),
        .ovf      (ctl.ovf),
        .sf_now   (ctl.sf),
        .res_calc (res_calc),
        .res_fast (res_fast)
    );

    always_comb begin
        void_op   = ctl.unalloc || ctl.unhandled;
        fast      = void_op || ctl.div_zero || ctl.ovf;
        accept    = (state_q == ST_IDLE) && start;
        core_load = accept && !fast;
        core_step = (state_q == ST_CALC);
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = fast ? ST_RESP : ST_CALC;
            ST_CALC:  if (core_last) state_d = ST_FINAL;
            ST_FINAL: state_d = ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // response registers
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            res_q <= '0;
            ua_q  <= 1'b0;
            uh_q  <= 1'b0;
            neg_l <= 1'b0;
            sf_l  <= 1'b0;
        end else begin
            if (accept) begin
                rd_q  <= ctl.rd;
                ua_q  <= ctl.unalloc;
                uh_q  <= ctl.unhandled;
                neg_l <= ctl.neg_q;
                sf_l  <= ctl.sf;
                if (fast) begin
                    res_q <= res_fast;
                end
            end
            if (state_q == ST_FINAL) begin
                res_q <= res_calc;
            end
        end
    end

    // outputs
    always_comb begin
        busy           = (state_q != ST_IDLE);
        done           = (state_q == ST_RESP);
        done_rd        = rd_q;
        done_result    = res_q;
        done_unalloc   = ua_q;
        done_unhandled = uh_q;
    end

endmodule

// File: rtl/intdiv_unit_chk.sv
module intdiv_unit_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            acc_sf,
    input logic [4:0]      acc_rd,
    input logic            busy,
    input logic            done,
    input logic [4:0]      done_rd,
    input logic [XLEN-1:0] done_result,
    input logic            done_unalloc,
    input logic            done_unhandled
);

    localparam int HALF = XLEN / 2;

    logic       cap_sf;
    logic [4:0] cap_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_sf <= 1'b1;
            cap_rd <= '0;
        end else if (start && !busy) begin
            cap_sf <= acc_sf;
            cap_rd <= acc_rd;
        end
    end

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

    // R12
    done_in_busy_chk: assert property (@(posedge clk) disable iff (rst) done |-> busy);

    // R11
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy);

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst) (busy && !done) |=> busy);

    // R11
    rd_stable_chk: assert property (@(posedge clk) disable iff (rst) busy |=> $stable(done_rd));

    // R1
    rd_echo_chk: assert property (@(posedge clk) disable iff (rst) done |-> (done_rd == cap_rd));

    // R10
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !cap_sf) |-> (done_result[XLEN-1:HALF] == '0));

    // R2
    unalloc_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done && done_unalloc) |-> (done_result == '0 && !done_unhandled));

    // R3
    unhandled_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done && done_unhandled) |-> (done_result == '0 && !done_unalloc));

    // R13
    reset_clear_chk: assert property (@(posedge clk) rst |=> (!busy && !done));

endmodule

bind intdiv_unit intdiv_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .start          (start),
    .acc_sf         (insn[31]),
    .acc_rd         (insn[4:0]),
    .busy           (busy),
    .done           (done),
    .done_rd        (done_rd),
    .done_result    (done_result),
    .done_unalloc   (done_unalloc),
    .done_unhandled (done_unhandled)
);

// File: tb/sim_intdiv_unit.sv
module sim_intdiv_unit;

    localparam int CLK_PERIOD = 10;
    localparam int XLEN       = 64;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] insn = '0;
    logic [63:0] src_n = '0;
    logic [63:0] src_m = '0;
    logic        busy;
    logic        done;
    logic [4:0]  done_rd;
    logic [63:0] done_result;
    logic        done_unalloc;
    logic        done_unhandled;

    int checks = 0;
    int fails  = 0;

    // behavioural model state
    int          m_left = 0;
    bit          m_done = 1'b0;
    logic [63:0] e_res = '0;
    bit          e_ua = 1'b0;
    bit          e_uh = 1'b0;
    bit          e_sf = 1'b1;
    logic [4:0]  e_rd = '0;
    string       e_req = "R12";

    always #(CLK_PERIOD/2) clk = ~clk;

    intdiv_unit #(.XLEN(XLEN)) u0 (
        .clk            (clk),
        .rst            (rst),
        .start          (start),
        .insn           (insn),
        .src_n          (src_n),
        .src_m          (src_m),
        .busy           (busy),
        .done           (done),
        .done_rd        (done_rd),
        .done_result    (done_result),
        .done_unalloc   (done_unalloc),
        .done_unhandled (done_unhandled)
    );

    task automatic cmp(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit wide, input bit sbit, input logic [5:0] op, input logic [4:0] rd);
        return {wide, 1'b0, sbit, 8'b11010110, 5'd2, op, 5'd1, rd};
    endfunction

    function automatic void predict(input logic [31:0] ins, input logic [63:0] a, input logic [63:0] b,
                                    output logic [63:0] r, output bit ua, output bit uh,
                                    output bit quick, output string req);
        logic [63:0] x;
        logic [63:0] y;
        longint      sx;
        longint      sy;
        bit          wide;
        bit          sgn;
        wide  = ins[31];
        sgn   = (ins[15:10] == 6'd3);
        r     = '0;
        ua    = 1'b0;
        uh    = 1'b0;
        quick = 1'b1;
        req   = "R4";
        if (ins[29]) begin
            ua  = 1'b1;
            req = "R2";
        end else if (ins[15:10] != 6'd2 && ins[15:10] != 6'd3) begin
            uh  = 1'b1;
            req = "R3";
        end else begin
            if (wide) begin
                x = a;
                y = b;
            end else if (sgn) begin
                x = {{32{a[31]}}, a[31:0]};
                y = {{32{b[31]}}, b[31:0]};
            end else begin
                x = {32'h0, a[31:0]};
                y = {32'h0, b[31:0]};
            end
            if (y == 64'h0) begin
                r   = '0;
                req = "R6";
            end else if (sgn && x == 64'h8000000000000000 && y == 64'hFFFFFFFFFFFFFFFF) begin
                r   = x;
                req = "R7";
            end else begin
                quick = 1'b0;
                if (sgn) begin
                    sx  = x;
                    sy  = y;
                    r   = sx / sy;
                    req = wide ? "R5" : "R8";
                end else begin
                    r   = x / y;
                    req = wide ? "R4" : "R9";
                end
            end
            if (!wide) r = {32'h0, r[31:0]};
        end
    endfunction

    // model advances on the same edge the design samples
    always @(posedge clk) begin : model
        bit          acc;
        logic [63:0] r;
        bit          ua;
        bit          uh;
        bit          q;
        string       rq;
        if (rst) begin
            m_left = 0;
            m_done = 1'b0;
        end else begin
            acc    = start && !(m_left > 0 || m_done);
            m_done = 1'b0;
            if (m_left > 0) begin
                m_left--;
                if (m_left == 0) m_done = 1'b1;
            end
            if (acc) begin
                predict(insn, src_n, src_m, r, ua, uh, q, rq);
                e_res = r;
                e_ua  = ua;
                e_uh  = uh;
                e_rd  = insn[4:0];
                e_sf  = insn[31];
                e_req = rq;
                if (q) m_done = 1'b1;
                else   m_left = XLEN + 1;
            end
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin : compare
        cmp("R11", "busy", 64'(busy), 64'(m_left > 0 || m_done));
        cmp("R12", "done", 64'(done), 64'(m_done));
        if (m_done && done) begin
            cmp("R1", "done_rd", 64'(done_rd), 64'(e_rd));
            cmp(e_req, "result", done_result, e_res);
            cmp("R2", "unalloc flag", 64'(done_unalloc), 64'(e_ua));
            cmp("R3", "unhandled flag", 64'(done_unhandled), 64'(e_uh));
            if (!e_sf) cmp("R10", "upper half", 64'(done_result[63:32]), 64'h0);
        end
    end

    task automatic drain();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run(input logic [31:0] ins, input logic [63:0] a, input logic [63:0] b);
        insn  = ins;
        src_n = a;
        src_m = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        drain();
    endtask

    task automatic hold_for(input int pulses);
        int seen = 0;
        while (seen < pulses) begin
            @(negedge clk);
            if (done) seen++;
        end
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        cmp("R13", "busy in reset", 64'(busy), 64'h0);
        cmp("R13", "done in reset", 64'(done), 64'h0);
        rst = 1'b0;
        @(negedge clk);

        // R4 unsigned 64-bit
        run(mk(1, 0, 6'd2, 5'd4), 64'd100, 64'd7);
        run(mk(1, 0, 6'd2, 5'd5), 64'hFFFFFFFFFFFFFFFF, 64'd3);
        run(mk(1, 0, 6'd2, 5'd6), 64'd5, 64'd10);
        run(mk(1, 0, 6'd2, 5'd31), 64'h8000000000000001, 64'hFFFFFFFFFFFFFFFF);
        // R5 signed 64-bit, truncation toward zero
        run(mk(1, 0, 6'd3, 5'd7), -64'sd7, 64'd2);
        run(mk(1, 0, 6'd3, 5'd8), 64'd7, -64'sd2);
        run(mk(1, 0, 6'd3, 5'd9), -64'sd7, -64'sd2);
        run(mk(1, 0, 6'd3, 5'd10), 64'h8000000000000000, 64'd2);
        run(mk(1, 0, 6'd3, 5'd11), 64'h8000000000000000, 64'd1);
        // R7 overflow case
        run(mk(1, 0, 6'd3, 5'd12), 64'h8000000000000000, 64'hFFFFFFFFFFFFFFFF);
        // R6 zero divisor
        run(mk(1, 0, 6'd2, 5'd13), 64'd1234, 64'd0);
        run(mk(1, 0, 6'd3, 5'd14), -64'sd1234, 64'd0);
        run(mk(0, 0, 6'd3, 5'd15), 64'd55, 64'hABCD000000000000);
        // R8 signed 32-bit, upper halves ignored
        run(mk(0, 0, 6'd3, 5'd16), 64'hDEADBEEFFFFFFFF9, 64'h1234567800000002);
        run(mk(0, 0, 6'd3, 5'd17), 64'h0000000080000000, 64'h00000000FFFFFFFF);
        // R9 unsigned 32-bit
        run(mk(0, 0, 6'd2, 5'd18), 64'hFFFFFFFFFFFFFFF9, 64'h0000000100000002);
        run(mk(0, 0, 6'd2, 5'd19), 64'h1234567800000064, 64'hFFFFFFFF0000000A);
        // R2 unallocated, R3 unhandled opcodes
        run(mk(1, 1, 6'd2, 5'd20), 64'd100, 64'd5);
        run(mk(1, 0, 6'd8, 5'd21), 64'd100, 64'd5);
        run(mk(0, 0, 6'd0, 5'd22), 64'd100, 64'd5);
        run(mk(1, 0, 6'd23, 5'd23), 64'd100, 64'd5);

        // R11 start held high across responses (immediate, then looped)
        insn  = mk(1, 0, 6'd2, 5'd3);
        src_n = 64'd9;
        src_m = 64'd0;
        start = 1'b1;
        hold_for(2);
        insn  = mk(1, 0, 6'd3, 5'd24);
        src_n = -64'sd1000;
        src_m = 64'd33;
        hold_for(2);
        start = 1'b0;
        drain();

        // R11 start pulse during a running divide is ignored
        insn  = mk(1, 0, 6'd2, 5'd25);
        src_n = 64'd1000;
        src_m = 64'd10;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        insn  = mk(1, 1, 6'd3, 5'd26);
        src_n = 64'd1;
        src_m = 64'd1;
        start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        drain();

        // R13 reset in the middle of a divide
        insn  = mk(1, 0, 6'd2, 5'd27);
        src_n = 64'd77777;
        src_m = 64'd7;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        cmp("R13", "busy after reset", 64'(busy), 64'h0);
        cmp("R13", "done after reset", 64'(done), 64'h0);
        run(mk(1, 0, 6'd2, 5'd28), 64'd77777, 64'd7);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule